// File: doc/BRIEF.md
# One-Step PTP Timestamp Inserter with Checksum-Neutral Pad

This block sits in a byte-wide Ethernet transmit path between a frame source and a MAC that appends the FCS. It looks for IPv4/UDP precision-time event frames that carry a Sync message meant for one-step operation. In each such frame it replaces the zeroed 10-byte origin timestamp with the time captured when the frame's first byte was accepted.

The sender computes the UDP checksum as if the timestamp were zero. It also appends a zeroed two-byte word at the end of the UDP payload. The block leaves the checksum field untouched. Instead it overwrites that trailing word with the ones'-complement negation of the inserted timestamp's contribution, so the datagram still verifies at the receiver.

Every other frame, and every byte outside the two edited regions, passes through unchanged. The data path is combinational. A byte leaves in the same cycle it is accepted, and the downstream ready signal is handed straight back upstream.

Top module: `ts1step_inserter`

## Requirements
- R1: With the block idle, `out_valid` is low. Every byte that is not edited appears on `out_data` in the same cycle it is presented, with `out_sof` and `out_eof` equal to `in_sof` and `in_eof`.
- R2: A frame is edited only when all of the following hold; any other frame leaves byte-for-byte unchanged:
  - bytes 12 and 13 are 0x08 0x00;
  - the high nibble of byte 14 is 4 and its low nibble (header length in 32-bit words) is at least 5;
  - byte 23 is 17;
  - the UDP destination port (UDP offset 2, big-endian) is 319;
  - the low nibble of UDP offset 8 is 0;
  - bit 1 of UDP offset 14 (the two-step flag) is 0;
  - the UDP length field (UDP offset 4, big-endian) is at least 54.
- R3: In an edited frame, UDP offsets 42 to 51 are replaced by `ts_sec` (48 bits) followed by `ts_nsec` (32 bits), both big-endian. The values are sampled when the first byte of the frame (`in_sof` high) is accepted. Later changes to these inputs during the frame have no effect.
- R4: When correction is active, the two bytes at UDP offsets L-2 and L-1 (L = UDP length) are rewritten. The rewrite leaves the ones'-complement sum over pseudo-header and datagram equal to its value before insertion, so the output verifies to 0xFFFF. Bytes past L-1 are untouched.
- R5: The pad equals the bitwise inverse of the fully end-around-folded sum of the five 16-bit timestamp words. With even L the inverse is written high byte first; with odd L it is written low byte first. An all-zero timestamp yields 0xFFFF, and a folded sum of 0xFFFF yields 0x0000. Low bytes of 0xFF are produced exactly.
- R6: The UDP checksum field (UDP offsets 6 and 7) is never modified.
- R7: With `en_fix` low at frame start, the timestamp is still inserted but the pad bytes pass through unchanged.
- R8: With `en_insert` low at frame start, the frame passes unchanged.
- R9: If the UDP checksum field is 0x0000, the timestamp is inserted and the pad bytes pass through unchanged.
- R10: The UDP header position follows the IPv4 header-length field, so IPv4 options move all UDP offsets.
- R11: `in_ready` always equals `out_ready` and `out_valid` equals `in_valid`. No bubble is added, and stalls and idle cycles anywhere in a frame do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_insert | input | 1 | Timestamp insertion enable, sampled at frame start |
| en_fix | input | 1 | Pad correction enable, sampled at frame start |
| ts_sec | input | 48 | Current time, seconds |
| ts_nsec | input | 32 | Current time, nanoseconds |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with `in_valid` |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame |

## Verification
On every accepted byte, the assertions confirm three things. The leading 42 bytes of any frame are never altered. Frames whose EtherType is not IPv4, or whose IP protocol is not UDP, pass through untouched. A frame that began with insertion disabled is never edited. Whether the timestamp lands in the right place and whether the pad makes the datagram verify can only be shown by the bench scenarios. These use a reference ones'-complement sum over each output datagram and cover end-around-carry corner timestamps, odd and even datagram lengths, header options, and stalls in the middle of a frame.

// File: rtl/ts1step_inserter.sv
module ts1step_inserter #(
  parameter int          IDX_W    = 16,
  parameter logic [15:0] PTP_PORT = 16'd319,
  parameter int          TS_OFS   = 34
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_insert,
  input  logic        en_fix,
  input  logic [47:0] ts_sec,
  input  logic [31:0] ts_nsec,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_sof,
  output logic        out_eof
);
  localparam int TS_REL   = 8 + TS_OFS;
  localparam int TS_LEN   = 10;
  localparam int MIN_ULEN = TS_REL + TS_LEN + 2;
  localparam logic [IDX_W-1:0] POS_MAX = '1;

  logic             fire;
  logic [IDX_W-1:0] cnt, pos, u_base, rel, len_x;
  logic [79:0]      ts_q;
  logic [15:0]      len_q;
  logic [7:0]       len_hi;
  logic [3:0]       ihl_q;
  logic             ins_q, fix_q;
  logic             eth_hi_ok, eth_ok, ip_ok, proto_ok;
  logic             port_hi_ok, port_ok, len_ok, cs_hi_nz, cs_nz, type_ok, flag_ok;

  assign fire      = in_valid & out_ready;
  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign out_sof   = in_sof;
  assign out_eof   = in_eof;

  assign pos    = in_sof ? '0 : cnt;
  assign u_base = IDX_W'(14) + IDX_W'({ihl_q, 2'b00});
  assign rel    = pos - u_base;
  assign len_x  = IDX_W'(len_q);

  logic in_udp;
  assign in_udp = (pos >= u_base);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= POS_MAX;
    end else if (fire) begin
      cnt <= (pos == POS_MAX) ? POS_MAX : pos + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q       <= '0;
      ins_q      <= 1'b0;
      fix_q      <= 1'b0;
      ihl_q      <= 4'd5;
      eth_hi_ok  <= 1'b0;
      eth_ok     <= 1'b0;
      ip_ok      <= 1'b0;
      proto_ok   <= 1'b0;
      port_hi_ok <= 1'b0;
      port_ok    <= 1'b0;
      len_hi     <= '0;
      len_q      <= '0;
      len_ok     <= 1'b0;
      cs_hi_nz   <= 1'b0;
      cs_nz      <= 1'b0;
      type_ok    <= 1'b0;
      flag_ok    <= 1'b0;
    end else if (fire) begin
      if (in_sof) begin
        ts_q     <= {ts_sec, ts_nsec};
        ins_q    <= en_insert;
        fix_q    <= en_fix;
        eth_ok   <= 1'b0;
        ip_ok    <= 1'b0;
        proto_ok <= 1'b0;
        port_ok  <= 1'b0;
        len_ok   <= 1'b0;
        cs_nz    <= 1'b0;
        type_ok  <= 1'b0;
        flag_ok  <= 1'b0;
      end
      if (pos == IDX_W'(12)) eth_hi_ok <= (in_data == 8'h08);
      if (pos == IDX_W'(13)) eth_ok    <= eth_hi_ok && (in_data == 8'h00);
      if (pos == IDX_W'(14)) begin
        ip_ok <= (in_data[7:4] == 4'd4) && (in_data[3:0] >= 4'd5);
        ihl_q <= in_data[3:0];
      end
      if (pos == IDX_W'(23)) proto_ok <= (in_data == 8'd17);
      if (in_udp && pos > IDX_W'(14)) begin
        if (rel == IDX_W'(2)) port_hi_ok <= (in_data == PTP_PORT[15:8]);
        if (rel == IDX_W'(3)) port_ok    <= port_hi_ok && (in_data == PTP_PORT[7:0]);
        if (rel == IDX_W'(4)) len_hi     <= in_data;
        if (rel == IDX_W'(5)) begin
          len_q  <= {len_hi, in_data};
          len_ok <= ({len_hi, in_data} >= 16'(MIN_ULEN));
        end
        if (rel == IDX_W'(6))  cs_hi_nz <= (in_data != 8'h00);
        if (rel == IDX_W'(7))  cs_nz    <= cs_hi_nz || (in_data != 8'h00);
        if (rel == IDX_W'(8))  type_ok  <= (in_data[3:0] == 4'd0);
        if (rel == IDX_W'(14)) flag_ok  <= !in_data[1];
      end
    end
  end

  logic target, fix_on, ts_hit, pad0_hit, pad1_hit;
  assign target = ins_q & eth_ok & ip_ok & proto_ok & port_ok & len_ok & type_ok & flag_ok;
  assign fix_on = target & fix_q & cs_nz;
  assign ts_hit = in_udp && (rel >= IDX_W'(TS_REL)) && (rel < IDX_W'(TS_REL + TS_LEN));
  assign pad0_hit = in_udp && (rel == len_x - IDX_W'(2));
  assign pad1_hit = in_udp && (rel == len_x - IDX_W'(1));

  logic [3:0] ts_idx;
  logic [6:0] ts_sh;
  logic [7:0] ts_byte;
  assign ts_idx  = 4'(rel - IDX_W'(TS_REL));
  assign ts_sh   = {4'd9 - ts_idx, 3'b000};
  assign ts_byte = 8'(ts_q >> ts_sh);

  logic [18:0] sum1;
  logic [16:0] sum2;
  logic [15:0] sum3, pad;
  assign sum1 = 19'(ts_q[79:64]) + 19'(ts_q[63:48]) + 19'(ts_q[47:32])
              + 19'(ts_q[31:16]) + 19'(ts_q[15:0]);
  assign sum2 = 17'(sum1[15:0]) + 17'(sum1[18:16]);
  assign sum3 = sum2[15:0] + 16'(sum2[16]);
  assign pad  = ~sum3;

  logic [7:0] pad_first, pad_second;
  assign pad_first  = len_q[0] ? pad[7:0]  : pad[15:8];
  assign pad_second = len_q[0] ? pad[15:8] : pad[7:0];

  always_comb begin
    out_data = in_data;
    if (target && ts_hit) out_data = ts_byte;
    if (fix_on && pad0_hit) out_data = pad_first;
    if (fix_on && pad1_hit) out_data = pad_second;
  end
endmodule

// File: rtl/ts1step_inserter_chk.sv
module ts1step_inserter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_insert,
  input logic       in_valid,
  input logic       out_ready,
  input logic [7:0] in_data,
  input logic       in_sof,
  input logic [7:0] out_data
);
  logic [15:0] c_cnt, c_pos;
  logic        c_fire, et_hi_bad, et_bad, pr_bad, ins_off;

  assign c_fire = in_valid && out_ready;
  assign c_pos  = in_sof ? 16'd0 : c_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_cnt     <= 16'hFFFF;
      et_hi_bad <= 1'b0;
      et_bad    <= 1'b0;
      pr_bad    <= 1'b0;
      ins_off   <= 1'b0;
    end else if (c_fire) begin
      c_cnt <= (c_pos == 16'hFFFF) ? c_pos : c_pos + 16'd1;
      if (in_sof) begin
        ins_off <= !en_insert;
        et_bad  <= 1'b0;
        pr_bad  <= 1'b0;
      end
      if (c_pos == 16'd12) et_hi_bad <= (in_data != 8'h08);
      if (c_pos == 16'd13) et_bad    <= et_hi_bad || (in_data != 8'h00);
      if (c_pos == 16'd23) pr_bad    <= (in_data != 8'd17);
    end
  end

  // R6: Ethernet, minimal IPv4 and UDP header bytes never change
  a_r6_hdr_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && c_pos < 16'd42) |-> (out_data == in_data));

  // R8: frame started with insertion off is forwarded as is
  a_r8_insert_off: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sof && ins_off) |-> (out_data == in_data));

  // R2: non-IPv4 frames are forwarded as is
  a_r2_not_ipv4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sof && et_bad) |-> (out_data == in_data));

  // R2: non-UDP frames are forwarded as is
  a_r2_not_udp: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sof && pr_bad) |-> (out_data == in_data));
endmodule

bind ts1step_inserter ts1step_inserter_chk u_chk (.*);

// File: tb/ts1step_inserter_bench.sv
`timescale 1ns/1ps
module ts1step_inserter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_insert = 1'b0, en_fix = 1'b0;
  logic [47:0] ts_sec = '0;
  logic [31:0] ts_nsec = '0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_sof, out_eof;
  logic [7:0]  out_data;

  always #5 clk = ~clk;

  ts1step_inserter u_ts1step_inserter (
    .clk(clk), .rst_n(rst_n), .en_insert(en_insert), .en_fix(en_fix),
    .ts_sec(ts_sec), .ts_nsec(ts_nsec),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof));

  int n_cmp = 0, n_bad = 0, hs_err = 0;
  bit done = 0;
  logic [7:0] fin [0:255];
  logic [7:0] fexp[0:255];
  logic [7:0] fout[0:255];
  int flen, fu;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] dgram_sum(input logic [7:0] a [0:255], input int ihl, input int ulen);
    int unsigned acc = 0;
    int u = 14 + 4 * ihl;
    for (int k = 26; k < 34; k += 2) acc += {a[k], a[k+1]};
    acc += 17;
    acc += ulen;
    for (int k = 0; k < ulen; k += 2) acc += {a[u+k], (k + 1 < ulen) ? a[u+k+1] : 8'h00};
    while (acc >> 16) acc = (acc & 32'hFFFF) + (acc >> 16);
    return acc[15:0];
  endfunction

  task automatic make_frame(input int ihl, input int ulen, input logic [15:0] etype,
                            input logic [7:0] proto, input logic [15:0] port,
                            input logic [3:0] mtype, input bit twostep, input bit csz);
    logic [15:0] cs;
    fu = 14 + 4 * ihl;
    flen = fu + ulen + 4;
    for (int k = 0; k < 256; k++) fin[k] = 8'(k * 7 + 3);
    fin[12] = etype[15:8]; fin[13] = etype[7:0];
    fin[14] = {4'h4, 4'(ihl)};
    fin[23] = proto;
    fin[fu+2] = port[15:8]; fin[fu+3] = port[7:0];
    fin[fu+4] = 8'(ulen >> 8); fin[fu+5] = 8'(ulen);
    fin[fu+6] = 8'h00; fin[fu+7] = 8'h00;
    fin[fu+8] = {4'h1, mtype};
    fin[fu+14] = twostep ? 8'h02 : 8'h00;
    for (int k = 42; k < 52; k++) fin[fu+k] = 8'h00;
    fin[fu+ulen-2] = 8'h00; fin[fu+ulen-1] = 8'h00;
    if (!csz) begin
      cs = ~dgram_sum(fin, ihl, ulen);
      if (cs == 16'h0000) cs = 16'hFFFF;
      fin[fu+6] = cs[15:8]; fin[fu+7] = cs[7:0];
    end
  endtask

  // R11: random-pattern stalls and idle cycles; handshake must mirror
  task automatic send_frame(input logic [47:0] sec, input logic [31:0] ns, input bit ins, input bit fix);
    int i = 0;
    int cyc = 0;
    hs_err = 0;
    @(negedge clk);
    ts_sec = sec; ts_nsec = ns; en_insert = ins; en_fix = fix;
    while (i < flen) begin
      out_ready = (cyc % 5) != 3;
      if (cyc % 7 == 2) in_valid = 1'b0;
      else begin
        in_valid = 1'b1; in_data = fin[i]; in_sof = (i == 0); in_eof = (i == flen - 1);
      end
      if (i > 0) begin ts_sec = ~sec; ts_nsec = ~ns; en_insert = !ins; en_fix = !fix; end
      #1;
      if (in_ready !== out_ready || out_valid !== in_valid) hs_err++;
      if (in_valid && out_ready) begin
        fout[i] = out_data;
        if (out_sof !== in_sof || out_eof !== in_eof) hs_err++;
        i++;
      end
      cyc++;
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; out_ready = 1'b1;
  endtask

  task automatic compare(input string req, input bit skip_pad, input int ulen);
    int nb = 0;
    int first = 0;
    for (int k = 0; k < flen; k++) begin
      if (!(skip_pad && (k == fu + ulen - 2 || k == fu + ulen - 1)) && fout[k] !== fexp[k]) begin
        if (nb == 0) first = k;
        nb++;
      end
    end
    check(nb == 0, req, $sformatf("frame bytes (first diff at %0d)", first), fout[first], fexp[first]);
    check(hs_err == 0, "R11", "handshake mirror errors", hs_err, 0);
  endtask

  task automatic run_case(input string req, input logic [47:0] sec, input logic [31:0] ns,
                          input int ihl, input int ulen, input bit ins, input bit fix, input bit csz,
                          input bit chk_pad, input logic [15:0] pad_bytes);
    logic [79:0] tsv;
    bit active_pad;
    make_frame(ihl, ulen, 16'h0800, 8'd17, 16'd319, 4'd0, 1'b0, csz);
    fexp = fin;
    tsv = {sec, ns};
    if (ins) for (int k = 0; k < 10; k++) fexp[fu+42+k] = tsv[79-8*k -: 8];
    active_pad = ins && fix && !csz;
    send_frame(sec, ns, ins, fix);
    compare(req, active_pad, ulen);
    check(fout[fu+6] === fin[fu+6] && fout[fu+7] === fin[fu+7], "R6", "checksum field",
          {fout[fu+6], fout[fu+7]}, {fin[fu+6], fin[fu+7]});
    if (active_pad)
      check(dgram_sum(fout, ihl, ulen) == 16'hFFFF, "R4", "datagram verify sum",
            dgram_sum(fout, ihl, ulen), 16'hFFFF);
    if (chk_pad)
      check({fout[fu+ulen-2], fout[fu+ulen-1]} === pad_bytes, req, "pad bytes",
            {fout[fu+ulen-2], fout[fu+ulen-1]}, pad_bytes);
  endtask

  task automatic run_pass(input string what, input logic [15:0] etype, input logic [7:0] proto,
                          input logic [15:0] port, input logic [3:0] mtype, input bit twostep, input int ulen);
    make_frame(5, ulen, etype, proto, port, mtype, twostep, 1'b0);
    fexp = fin;
    send_frame(48'h0000_1234_5678, 32'h1111_2222, 1'b1, 1'b1);
    compare({"R2 ", what}, 1'b0, ulen);
  endtask

  task automatic t_reset;
    #1;
    check(out_valid === 1'b0, "R1", "out_valid idle", out_valid, 0);
    check(in_ready === 1'b1, "R1", "in_ready follows out_ready", in_ready, 1);
  endtask

  task automatic t_basic;
    run_case("R3", 48'h0000_6543_2100, 32'h1234_5678, 5, 54, 1, 1, 0, 0, 16'h0);
  endtask

  task automatic t_odd_len;
    // R5: T = 0x1C21, pad 0xE3DE, odd length -> low byte first
    run_case("R5", 48'h0001_0203_0405, 32'h0A0B_0C0D, 5, 57, 1, 1, 0, 1, 16'hDEE3);
  endtask

  task automatic t_options;
    // R10: eight-word IPv4 header shifts the UDP header
    run_case("R10", 48'h0000_0A0A_0B0B, 32'h3B9A_C9FF, 8, 60, 1, 1, 0, 0, 16'h0);
  endtask

  task automatic t_corners;
    run_case("R5", 48'h0, 32'h0, 5, 54, 1, 1, 0, 1, 16'hFFFF);
    run_case("R5", 48'h0000_0000_FFFF, 32'h0, 5, 54, 1, 1, 0, 1, 16'h0000);
    run_case("R5", 48'h0000_0000_1200, 32'h0, 5, 54, 1, 1, 0, 1, 16'hEDFF);
    run_case("R5", 48'hFFFF_0001_0000, 32'hFFFF_FFFF, 5, 54, 1, 1, 0, 1, 16'hFFFE);
    run_case("R5", 48'h0000_0000_1200, 32'h0, 5, 55, 1, 1, 0, 1, 16'hFFED);
  endtask

  task automatic t_nontarget;
    run_pass("ethertype", 16'h86DD, 8'd17, 16'd319, 4'd0, 1'b0, 54);
    run_pass("protocol", 16'h0800, 8'd6, 16'd319, 4'd0, 1'b0, 54);
    run_pass("port", 16'h0800, 8'd17, 16'd320, 4'd0, 1'b0, 54);
    run_pass("message type", 16'h0800, 8'd17, 16'd319, 4'd8, 1'b0, 54);
    run_pass("two-step flag", 16'h0800, 8'd17, 16'd319, 4'd0, 1'b1, 54);
    run_pass("short length", 16'h0800, 8'd17, 16'd319, 4'd0, 1'b0, 50);
  endtask

  task automatic t_fix_off;
    run_case("R7", 48'h0000_0000_1200, 32'h5555_AAAA, 5, 54, 1, 0, 0, 1, 16'h0000);
  endtask

  task automatic t_ins_off;
    run_case("R8", 48'h0000_0000_1200, 32'h5555_AAAA, 5, 54, 0, 1, 0, 1, 16'h0000);
  endtask

  task automatic t_cs_zero;
    run_case("R9", 48'h0000_7777_8888, 32'h0102_0304, 5, 54, 1, 1, 1, 1, 16'h0000);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_odd_len();
    t_options();
    t_corners();
    t_nontarget();
    t_fix_off();
    t_ins_off();
    t_cs_zero();
    done = 1;
    finish_run();
  end
endmodule